// File: doc/BRIEF.md
# Interrupt Status and Request Generator

This block holds the control word and the status word of a conversion and vector-transform peripheral, and it drives the peripheral's active-low interrupt request line. Single-cycle completion strobes arrive from the A/D sequencer and from the rotation engine. Each strobe is gated by its own enable bit in the control word. An enabled strobe sets a sticky flag and a summary flag in the status word, and it asserts the request line.

Software reaches the two registers through a simple register bus. One select bit picks the register, and write and read strobes act on it. Read data is combinational and shows the register before the edge that ends the read. Reading the status register clears the sticky flags. In level mode the same read releases the request line. A results-valid flag follows the rotation engine: a transform start clears it and a transform completion sets it. The control word also exports the two channel-enable bits to the sequencer and selects a divide-by-two system clock enable. All logic runs on the input clock.

Top module: `cvt_irq_hub`

## Requirements
- R1: After a synchronous reset, the control word reads 0, the status word reads 0, irq_n is 1 and sys_clk_en is 1.
- R2: A write with bus_sel=0 stores only control bits 3 to 8; every other bit reads back as 0. chan_u_en follows control bit 3 and chan_aux_en follows control bit 4 from the cycle after the write.
- R3: An adc_done strobe sets status bit 0 at the next edge when control bit 7 is 1. With control bit 7 at 0, the strobe changes nothing.
- R4: An xform_done strobe sets status bit 1 at the next edge when control bit 6 is 1. With control bit 6 at 0, status bit 1 is not set.
- R5: Status bit 11 sets at the next edge whenever an enabled strobe (R3 or R4) occurs.
- R6: A read with bus_sel=1 returns the status word as it was before the edge. That edge clears status bits 0, 1 and 11 and leaves bit 4 unchanged.
- R7: When an enabled strobe and a status read fall in the same cycle, the flag set wins: the flag and bit 11 read 1 afterwards. In level mode irq_n stays 0.
- R8: With control bit 8 at 0, each cycle with an enabled strobe drives irq_n to 0 for exactly one cycle, starting at the next edge.
- R9: With control bit 8 at 1, an enabled strobe drives irq_n to 0 at the next edge. irq_n stays 0 until the edge that ends a status read, and then returns to 1.
- R10: Status bit 4 sets at the edge after any xform_done strobe, whatever the enables are. It clears at the edge after an xform_start strobe. If both strobes fall in the same cycle, the set wins.
- R11: With control bit 5 at 0, sys_clk_en is constantly 1. With control bit 5 at 1, sys_clk_en is 1 in the first cycle after the bit takes effect and then alternates every cycle.
- R12: A write with bus_sel=1 has no effect on the status word. A strobe whose enable bit is 0 never drives irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 = control, 1 = status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| adc_done | input | 1 | A/D conversion complete strobe |
| xform_done | input | 1 | Vector transform complete strobe |
| xform_start | input | 1 | Vector transform start strobe |
| irq_n | output | 1 | Active-low interrupt request |
| sys_clk_en | output | 1 | System clock enable (full or half rate) |
| chan_u_en | output | 1 | U channel conversion enable to the sequencer |
| chan_aux_en | output | 1 | AUX channel conversion enable to the sequencer |

## Verification
The bench aims at a strobe that lands in the same cycle as a status read. A design in which the clear wins there would lose the event and release a held request. It also checks that a status read leaves the results-valid bit alone, that a start and a done in the same cycle leave that bit set, and that a disabled strobe does not disturb the request line. A design that got any of these wrong would clear bit 4 on a read or drop the valid flag on the collision. Pulse mode is checked for exactly one low cycle, so a stretched or missing pulse shows up. Level mode is checked for holding the line through idle cycles, so a line that released early would be caught.

// File: rtl/cvt_irq_pkg.sv
package cvt_irq_pkg;

    localparam int WORD_W = 16;

    // control bit positions
    localparam int CB_CHAN_U   = 3;
    localparam int CB_CHAN_AUX = 4;
    localparam int CB_DIV2     = 5;
    localparam int CB_XF_IE    = 6;
    localparam int CB_ADC_IE   = 7;
    localparam int CB_LEVEL    = 8;

    // status bit positions
    localparam int SB_ADC = 0;
    localparam int SB_XF  = 1;
    localparam int SB_ROT = 4;
    localparam int SB_ANY = 11;

    // writable control bits: CB_CHAN_U .. CB_LEVEL
    localparam logic [WORD_W-1:0] CTRL_MASK =
        WORD_W'(((1 << (CB_LEVEL + 1)) - 1) & ~((1 << CB_CHAN_U) - 1));

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic level;
        logic adc_ie;
        logic xf_ie;
        logic div2;
        logic chan_aux;
        logic chan_u;
    } ctrl_t;

    typedef struct packed {
        logic any;
        logic rot;
        logic xf;
        logic adc;
    } stat_t;

    function automatic ctrl_t ctrl_decode(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.level    = w[CB_LEVEL];
        c.adc_ie   = w[CB_ADC_IE];
        c.xf_ie    = w[CB_XF_IE];
        c.div2     = w[CB_DIV2];
        c.chan_aux = w[CB_CHAN_AUX];
        c.chan_u   = w[CB_CHAN_U];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] stat_encode(input stat_t s);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[SB_ADC] = s.adc;
        w[SB_XF]  = s.xf;
        w[SB_ROT] = s.rot;
        w[SB_ANY] = s.any;
        return w;
    endfunction

endpackage

// File: rtl/cvt_ctrl_reg.sv
module cvt_ctrl_reg
    import cvt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_word,
    output ctrl_t             ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_word <= '0;
        else if (wr_stb)
            ctrl_word <= wdata & CTRL_MASK;
    end

    assign ctrl = ctrl_decode(ctrl_word);

    // control word only changes on a control write
    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(ctrl_word));

endmodule

// File: rtl/cvt_stat_flags.sv
module cvt_stat_flags
    import cvt_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adc_done,
    input  logic  xform_done,
    input  logic  xform_start,
    input  logic  stat_rd,
    input  logic  adc_ie,
    input  logic  xf_ie,
    output stat_t flags,
    output logic  any_hit
);

    logic adc_hit;
    logic xf_hit;

    assign adc_hit = adc_done & adc_ie;
    assign xf_hit  = xform_done & xf_ie;
    assign any_hit = adc_hit | xf_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            // a set in the read cycle wins over the clear
            flags.adc <= (flags.adc & ~stat_rd) | adc_hit;
            flags.xf  <= (flags.xf  & ~stat_rd) | xf_hit;
            flags.any <= (flags.any & ~stat_rd) | any_hit;
            if (xform_done)
                flags.rot <= 1'b1;
            else if (xform_start)
                flags.rot <= 1'b0;
        end
    end

    assert_adc_set_R3: assert property (@(posedge clk) disable iff (rst)
        adc_hit |=> flags.adc);
    assert_adc_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (adc_done && !adc_ie && !flags.adc) |=> !flags.adc);
    assert_xf_set_R4: assert property (@(posedge clk) disable iff (rst)
        xf_hit |=> flags.xf);
    assert_any_set_R5: assert property (@(posedge clk) disable iff (rst)
        (adc_done || xform_done) && any_hit |=> flags.any);
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !adc_done && !xform_done) |=> (!flags.adc && !flags.xf && !flags.any));
    assert_read_keeps_rot_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !xform_done && !xform_start) |=> $stable(flags.rot));
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && adc_hit) |=> (flags.adc && flags.any));
    assert_rot_set_R10: assert property (@(posedge clk) disable iff (rst)
        xform_done |=> flags.rot);
    assert_rot_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (xform_start && !xform_done) |=> !flags.rot);

endmodule

// File: rtl/cvt_irq_drive.sv
module cvt_irq_drive (
    input  logic clk,
    input  logic rst,
    input  logic any_hit,
    input  logic stat_rd,
    input  logic level_mode,
    output logic irq_n
);

    logic irq_low_q;

    always_ff @(posedge clk) begin
        if (rst)
            irq_low_q <= 1'b0;
        else if (level_mode)
            irq_low_q <= (irq_low_q & ~stat_rd) | any_hit;
        else
            irq_low_q <= any_hit;
    end

    assign irq_n = ~irq_low_q;

    assert_irq_fire_R8: assert property (@(posedge clk) disable iff (rst)
        any_hit |=> !irq_n);
    assert_pulse_end_R8: assert property (@(posedge clk) disable iff (rst)
        (!level_mode && !any_hit) |=> irq_n);
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (level_mode && !irq_n && !stat_rd) |=> !irq_n);
    assert_level_release_R9: assert property (@(posedge clk) disable iff (rst)
        (level_mode && stat_rd && !any_hit) |=> irq_n);

endmodule

// File: rtl/cvt_clk_half.sv
module cvt_clk_half (
    input  logic clk,
    input  logic rst,
    input  logic div2,
    output logic sys_clk_en
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= 1'b1;
        else if (div2)
            phase_q <= ~phase_q;
        else
            phase_q <= 1'b1;
    end

    assign sys_clk_en = div2 ? phase_q : 1'b1;

    assert_full_rate_R11: assert property (@(posedge clk) disable iff (rst)
        !div2 |-> sys_clk_en);
    assert_half_rate_R11: assert property (@(posedge clk) disable iff (rst)
        (div2 && sys_clk_en) |=> (!sys_clk_en || !div2));

endmodule

// File: rtl/cvt_irq_hub.sv
module cvt_irq_hub
    import cvt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              adc_done,
    input  logic              xform_done,
    input  logic              xform_start,
    output logic              irq_n,
    output logic              sys_clk_en,
    output logic              chan_u_en,
    output logic              chan_aux_en
);

    logic              ctrl_wr;
    logic              stat_rd;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] stat_word;
    ctrl_t             ctrl;
    stat_t             flags;
    logic              any_hit;

    assign ctrl_wr = bus_wr & (bus_sel == SEL_CTRL);
    assign stat_rd = bus_rd & (bus_sel == SEL_STAT);

    cvt_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (ctrl_wr),
        .wdata     (bus_wdata),
        .ctrl_word (ctrl_word),
        .ctrl      (ctrl)
    );

    cvt_stat_flags u_stat (
        .clk         (clk),
        .rst         (rst),
        .adc_done    (adc_done),
        .xform_done  (xform_done),
        .xform_start (xform_start),
        .stat_rd     (stat_rd),
        .adc_ie      (ctrl.adc_ie),
        .xf_ie       (ctrl.xf_ie),
        .flags       (flags),
        .any_hit     (any_hit)
    );

    cvt_irq_drive u_irq (
        .clk        (clk),
        .rst        (rst),
        .any_hit    (any_hit),
        .stat_rd    (stat_rd),
        .level_mode (ctrl.level),
        .irq_n      (irq_n)
    );

    cvt_clk_half u_clk (
        .clk        (clk),
        .rst        (rst),
        .div2       (ctrl.div2),
        .sys_clk_en (sys_clk_en)
    );

    assign stat_word   = stat_encode(flags);
    assign bus_rdata   = (bus_sel == SEL_STAT) ? stat_word : ctrl_word;
    assign chan_u_en   = ctrl.chan_u;
    assign chan_aux_en = ctrl.chan_aux;

    // disabled strobes never pull the request line
    assert_no_spurious_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !ctrl.level && !(adc_done && ctrl.adc_ie) && !(xform_done && ctrl.xf_ie)) |=> irq_n);

endmodule

// File: tb/cvt_irq_hub_tb_top.sv
module cvt_irq_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd, bus_sel;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        adc_done, xform_done, xform_start;
    logic        irq_n, sys_clk_en, chan_u_en, chan_aux_en;

    int tests_run = 0;
    int tests_fail = 0;
    bit finished = 0;

    // reference state
    logic [15:0] m_ctrl;
    logic        m_s0, m_s1, m_s4, m_s11, m_irq, m_ph;

    always #5 clk = ~clk;

    cvt_irq_hub dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .adc_done(adc_done),
        .xform_done(xform_done), .xform_start(xform_start), .irq_n(irq_n),
        .sys_clk_en(sys_clk_en), .chan_u_en(chan_u_en), .chan_aux_en(chan_aux_en)
    );

    function automatic logic [15:0] exp_stat();
        logic [15:0] w = 16'h0000;
        w[0] = m_s0; w[1] = m_s1; w[4] = m_s4; w[11] = m_s11;
        return w;
    endfunction

    function automatic logic [15:0] exp_rd(input logic sel);
        return sel ? exp_stat() : m_ctrl;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        tests_run++;
        if (got !== exp) begin
            tests_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 16'h0000; m_s0 = 0; m_s1 = 0; m_s4 = 0; m_s11 = 0; m_irq = 0; m_ph = 1;
    endtask

    // one bus/strobe cycle; starts and ends at a falling edge
    task automatic cyc(input string tag, input logic wr, input logic rd, input logic sel,
                       input logic [15:0] wd, input logic adc, input logic xf, input logic st);
        logic srd, cwr, ahit, xhit, hit;
        bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = wd;
        adc_done = adc; xform_done = xf; xform_start = st;
        #1;
        chk({tag, " rdata"}, bus_rdata, exp_rd(sel));
        @(posedge clk);
        srd  = rd & sel;
        cwr  = wr & ~sel;
        ahit = adc & m_ctrl[7];
        xhit = xf & m_ctrl[6];
        hit  = ahit | xhit;
        m_irq = m_ctrl[8] ? ((m_irq & ~srd) | hit) : hit;
        m_ph  = m_ctrl[5] ? ~m_ph : 1'b1;
        m_s0  = (m_s0 & ~srd) | ahit;
        m_s1  = (m_s1 & ~srd) | xhit;
        m_s11 = (m_s11 & ~srd) | hit;
        if (xf) m_s4 = 1'b1; else if (st) m_s4 = 1'b0;
        if (cwr) m_ctrl = wd & 16'h01F8;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; adc_done = 0; xform_done = 0; xform_start = 0;
        chk({tag, " irq_n"}, {15'd0, irq_n}, {15'd0, ~m_irq});
        chk({tag, " sys_clk_en"}, {15'd0, sys_clk_en}, {15'd0, (m_ctrl[5] ? m_ph : 1'b1)});
        chk({tag, " chan"}, {14'd0, chan_aux_en, chan_u_en}, {14'd0, m_ctrl[4], m_ctrl[3]});
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 1, 16'h0, 0, 0, 0);
    endtask

    task automatic wr_ctrl(input string tag, input logic [15:0] v);
        cyc(tag, 1, 0, 0, v, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            tests_run++;
            tests_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] seed_dummy;
        seed_dummy = 16'($urandom(32'd24681));
        bus_wr = 0; bus_rd = 0; bus_sel = 0; bus_wdata = 0;
        adc_done = 0; xform_done = 0; xform_start = 0;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        bus_sel = 0; #1; chk("R1 ctrl", bus_rdata, 16'h0000);
        bus_sel = 1; #1; chk("R1 stat", bus_rdata, 16'h0000);
        chk("R1 irq_n", {15'd0, irq_n}, 16'h0001);
        chk("R1 clk_en", {15'd0, sys_clk_en}, 16'h0001);
        @(negedge clk);

        // R2 reserved bits masked, channel enables exported
        wr_ctrl("R2", 16'hFFFF);
        bus_sel = 0; #1; chk("R2 mask", bus_rdata, 16'h01F8);
        chk("R2 chans", {14'd0, chan_aux_en, chan_u_en}, 16'h0003);
        @(negedge clk);
        wr_ctrl("R2", 16'h0000);

        // R3/R12 disabled strobe sets nothing
        cyc("R12", 0, 0, 1, 0, 1, 0, 0);
        chk("R12 irq_n", {15'd0, irq_n}, 16'h0001);
        idle("R3", 1);

        // R3/R5/R8 enabled adc strobe, pulse mode
        wr_ctrl("R3", 16'h0080);
        cyc("R8", 0, 0, 1, 0, 1, 0, 0);
        chk("R8 low", {15'd0, irq_n}, 16'h0000);
        idle("R8", 1);
        chk("R8 high", {15'd0, irq_n}, 16'h0001);

        // R6 read returns then clears
        bus_sel = 1; #1; chk("R5 stat", bus_rdata, 16'h0801);
        @(negedge clk);
        cyc("R6", 0, 1, 1, 0, 0, 0, 0);
        bus_sel = 1; #1; chk("R6 cleared", bus_rdata, 16'h0000);
        @(negedge clk);

        // R4/R10 transform flags
        wr_ctrl("R4", 16'h0040);
        cyc("R4", 0, 0, 1, 0, 0, 1, 0);
        bus_sel = 1; #1; chk("R4 stat", bus_rdata, 16'h0812);
        @(negedge clk);
        cyc("R6", 0, 1, 1, 0, 0, 0, 0);
        bus_sel = 1; #1; chk("R6 keeps rot", bus_rdata, 16'h0010);
        @(negedge clk);
        cyc("R10", 0, 0, 1, 0, 0, 0, 1);
        bus_sel = 1; #1; chk("R10 start clears", bus_rdata, 16'h0000);
        @(negedge clk);
        cyc("R10", 0, 0, 1, 0, 0, 1, 1);
        bus_sel = 1; #1; chk("R10 done wins", bus_rdata[4:0], 16'h0012);
        @(negedge clk);
        cyc("R6", 0, 1, 1, 0, 0, 0, 0);

        // R9 level mode hold and release
        wr_ctrl("R9", 16'h01C0);
        cyc("R9", 0, 0, 1, 0, 1, 0, 0);
        idle("R9", 4);
        chk("R9 held", {15'd0, irq_n}, 16'h0000);
        cyc("R9", 0, 1, 1, 0, 0, 0, 0);
        chk("R9 released", {15'd0, irq_n}, 16'h0001);

        // R7 event during read
        cyc("R7", 0, 0, 1, 0, 1, 0, 0);
        cyc("R7", 0, 1, 1, 0, 1, 0, 0);
        chk("R7 irq held", {15'd0, irq_n}, 16'h0000);
        bus_sel = 1; #1; chk("R7 flag kept", bus_rdata, 16'h0811);
        @(negedge clk);
        cyc("R7", 0, 1, 1, 0, 0, 0, 0);

        // R12 status write ignored
        cyc("R12", 1, 0, 1, 16'hFFFF, 0, 0, 0);
        bus_sel = 1; #1; chk("R12 stat write", bus_rdata, 16'h0010);
        @(negedge clk);

        // R11 half-rate enable
        wr_ctrl("R11", 16'h0020);
        chk("R11 first", {15'd0, sys_clk_en}, 16'h0001);
        idle("R11", 1);
        chk("R11 second", {15'd0, sys_clk_en}, 16'h0000);
        idle("R11", 5);
        wr_ctrl("R11", 16'h0000);
        idle("R11", 2);

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic w, r, s, a, x, t;
            logic [15:0] d;
            w = (($urandom % 8) == 0);
            r = (($urandom % 3) == 0);
            s = 1'($urandom);
            d = 16'($urandom);
            a = (($urandom % 4) == 0);
            x = (($urandom % 4) == 0);
            t = (($urandom % 6) == 0);
            cyc("RAND", w, r, s, d, a, x, t);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

endmodule